// File: doc/BRIEF.md
# Way-Lockable Set-Associative Instruction Cache

This block is a read-only instruction cache with four ways per set. A processor fetch port looks up word-aligned addresses. On a hit the instruction comes back one cycle later. On a miss the cache fetches a whole line from a slower backing store over a request/ready handshake, writes the line into a chosen way, and then returns the requested word.

Each set has a lock bit that software writes through a small control port. While a set is locked, its protected way (way 0) is never picked as a replacement victim. The other ways of that set keep taking refills under normal pseudo-LRU replacement. To guarantee hit timing for deadline-critical code, software fetches that code once so that it lands in the cache, and then sets the lock. Every later access to the code then hits, however much other code competes for the same set. The cost is that unlocked code in that set has only three usable ways.

A global invalidate input empties the cache, including locked ways. It leaves the lock bits alone, so a locked set catches its critical line again on the next miss.

Top module: `wlock_icache`

## Requirements
- R1: After reset, fetch_ready_o is 1, fetch_valid_o is 0, mem_req_o is 0, every line is invalid and every lock bit is 0, so the first fetch of any address misses.
- R2: Fetch addresses are word aligned (bits 1:0 zero). An accepted fetch that misses raises mem_req_o in the next cycle. mem_addr_o then carries the line address: the fetch address with bits 3:0 cleared. Both stay stable until mem_ready_i is sampled high.
- R3: On the clock edge where mem_req_o and mem_ready_i are both 1, the whole line is stored, with word i taken from mem_line_i bits [32i+31:32i]. In the next cycle fetch_valid_o is 1 for exactly one cycle with fetch_hit_o 0, and fetch_data_o is word addr[3:2] of the line.
- R4: An accepted fetch to a resident line gives fetch_valid_o 1 and fetch_hit_o 1 in the next cycle, with the addressed word, and raises no mem_req_o. This holds for every word of the line.
- R5: The set index is addr[9:4] and the tag is addr[31:10]. Lines with the same index and different tags live in different ways. Invalid ways are filled first, lowest index first. Once all four ways are valid, a tree pseudo-LRU picks the victim. So when four lines are filled in order with no other accesses, a fifth conflicting line evicts the first.
- R6: A cycle with lock_we_i 1 writes lock_val_i into the lock bit of set lock_set_i. While that bit is 1 and way 0 of the set is valid, no refill of the set replaces way 0. The line in way 0 keeps hitting after any number of conflicting misses, and the other ways keep accepting refills.
- R7: If a set is locked while way 0 is invalid, the next miss in that set fills way 0. From then on that line is protected.
- R8: Writing a lock bit changes no tag, data or valid state. A line that was resident before the write still hits after it.
- R9: A cycle with flush_i 1 invalidates every line, locked ways included, so that later fetches miss. Lock bits keep their values across the flush.
- R10: fetch_ready_o is 0 while a refill is outstanding and while flush_i is 1. A fetch request presented then is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all lines |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 32 | Fetch byte address, word aligned |
| fetch_ready_o | output | 1 | Cache can accept a fetch this cycle |
| fetch_valid_o | output | 1 | One-cycle response strobe |
| fetch_hit_o | output | 1 | Response was served without a refill |
| fetch_data_o | output | 32 | Returned instruction word |
| mem_req_o | output | 1 | Line refill request to backing memory |
| mem_addr_o | output | 32 | Line-aligned refill address |
| mem_ready_i | input | 1 | Backing memory presents the line |
| mem_line_i | input | 128 | Refill line, word 0 in the low bits |
| lock_we_i | input | 1 | Lock bit write strobe |
| lock_set_i | input | 6 | Set whose lock bit is written |
| lock_val_i | input | 1 | New lock bit value |

## Verification
The lookup is driven with repeated words of one line, with neighbouring sets, and with two tags sharing one index. This separates offset decoding, index decoding and tag comparison. Five conflicting lines in an unlocked set show the pseudo-LRU eviction. More than twice as many conflicting lines as ways, sent into a locked set, show that the pinned line survives while the other ways keep turning over. Locking an empty set shows the one-time fill of the protected way. A flush followed by refills shows that validity is lost while the lock is kept. A request presented during a refill must stay unanswered.

// File: rtl/wlock_icache_pkg.sv
package wlock_icache_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_FILL = 1'b1
   } fill_state_t;

endpackage

// File: rtl/wlock_plru.sv
// Tree pseudo-LRU for one set: victim lookup and touch update.
// Node n (1..WAYS-1) holds a bit; 0 steers to the lower half.
module wlock_plru #(
   parameter int WAYS  = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:1]  bits_i,
   input  logic [WAY_W-1:0] touch_i,
   output logic [WAYS-1:1]  bits_o,
   output logic [WAY_W-1:0] victim_o
);

   logic [WAY_W-1:0] vnode;
   logic [WAY_W-1:0] unode;
   logic [WAY_W-1:0] tsh;
   logic             vdir;
   logic             udir;

   // walk toward the less recently used leaf
   always_comb begin
      vnode    = WAY_W'(1);
      victim_o = '0;
      vdir     = 1'b0;
      for (int l = 0; l < WAY_W; l++) begin
         vdir = bits_i[vnode];
         if (l == WAY_W - 1) begin
            victim_o = {vnode[WAY_W-2:0], vdir};
         end else begin
            vnode = {vnode[WAY_W-2:0], vdir};
         end
      end
   end

   // point every node on the touched path away from it
   always_comb begin
      bits_o = bits_i;
      unode  = WAY_W'(1);
      udir   = 1'b0;
      tsh    = '0;
      for (int l = 0; l < WAY_W; l++) begin
         tsh           = touch_i << l;
         udir          = tsh[WAY_W-1];
         bits_o[unode] = ~udir;
         if (l != WAY_W - 1) begin
            unode = {unode[WAY_W-2:0], udir};
         end
      end
   end

endmodule

// File: rtl/wlock_victim.sv
// Replacement choice: an invalid way first, else pseudo-LRU,
// never the protected way when the set is locked and that way is valid.
module wlock_victim #(
   parameter int WAYS     = 4,
   parameter int LOCK_WAY = 0,
   localparam int WAY_W   = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  valid_i,
   input  logic             lock_i,
   input  logic [WAY_W-1:0] plru_way_i,
   output logic [WAY_W-1:0] way_o
);

   localparam logic [WAY_W-1:0] PROT_WAY = WAY_W'(LOCK_WAY);
   localparam logic [WAY_W-1:0] ALT_WAY  = WAY_W'(LOCK_WAY) ^ WAY_W'(1);

   logic found;

   always_comb begin
      found = 1'b0;
      way_o = plru_way_i;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !valid_i[w]) begin
            way_o = WAY_W'(w);
            found = 1'b1;
         end
      end
      if (!found && lock_i && (plru_way_i == PROT_WAY)) begin
         way_o = ALT_WAY;
      end
   end

endmodule

// File: rtl/wlock_store.sv
// Tag, valid, line data and replacement state arrays.
module wlock_store #(
   parameter int WAYS       = 4,
   parameter int SETS       = 64,
   parameter int LINE_WORDS = 4,
   parameter int TAG_W      = 22,
   parameter int DATA_W     = 32,
   localparam int WAY_W     = $clog2(WAYS),
   localparam int SET_W     = $clog2(SETS),
   localparam int WORD_W    = $clog2(LINE_WORDS),
   localparam int LINE_W    = LINE_WORDS * DATA_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush_i,
   input  logic [SET_W-1:0]           idx_i,
   input  logic [WAY_W-1:0]           way_sel_i,
   input  logic [WORD_W-1:0]          word_sel_i,
   output logic [WAYS-1:0][TAG_W-1:0] rd_tag_o,
   output logic [WAYS-1:0]            rd_valid_o,
   output logic [WAYS-1:1]            rd_plru_o,
   output logic [DATA_W-1:0]          rd_word_o,
   input  logic                       fill_we_i,
   input  logic [WAY_W-1:0]           fill_way_i,
   input  logic [TAG_W-1:0]           fill_tag_i,
   input  logic [LINE_W-1:0]          fill_line_i,
   input  logic                       plru_we_i,
   input  logic [WAYS-1:1]            plru_i
);

   logic [SETS-1:0][WAYS-1:0]             valid_q;
   logic [SETS-1:0][WAYS-1:1]             plru_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (flush_i) begin
         valid_q <= '0;
      end else if (fill_we_i) begin
         valid_q[idx_i][fill_way_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plru_q <= '0;
      end else if (plru_we_i) begin
         plru_q[idx_i] <= plru_i;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we_i) begin
         tag_q[idx_i][fill_way_i]  <= fill_tag_i;
         data_q[idx_i][fill_way_i] <= fill_line_i;
      end
   end

   assign rd_tag_o   = tag_q[idx_i];
   assign rd_valid_o = valid_q[idx_i];
   assign rd_plru_o  = plru_q[idx_i];
   assign rd_word_o  = data_q[idx_i][way_sel_i][word_sel_i*DATA_W +: DATA_W];

   // R9: a flush leaves no valid line anywhere, locked ways included
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (valid_q == '0));

endmodule

// File: rtl/wlock_icache.sv
// Read-only set-associative instruction cache with per-set way locking.
module wlock_icache
   import wlock_icache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int WAYS       = 4,
   parameter int SETS       = 64,
   parameter int LINE_WORDS = 4,
   parameter int LOCK_WAY   = 0,
   localparam int WAY_W     = $clog2(WAYS),
   localparam int SET_W     = $clog2(SETS),
   localparam int WORD_W    = $clog2(LINE_WORDS),
   localparam int BYTE_W    = $clog2(DATA_W / 8),
   localparam int OFS_W     = WORD_W + BYTE_W,
   localparam int TAG_W     = ADDR_W - SET_W - OFS_W,
   localparam int LINE_W    = LINE_WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              fetch_req_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   output logic              fetch_ready_o,
   output logic              fetch_valid_o,
   output logic              fetch_hit_o,
   output logic [DATA_W-1:0] fetch_data_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ready_i,
   input  logic [LINE_W-1:0] mem_line_i,
   input  logic              lock_we_i,
   input  logic [SET_W-1:0]  lock_set_i,
   input  logic              lock_val_i
);

   // elaboration-time parameter checks
   if (WAYS < 4 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 4");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (LOCK_WAY < 0 || LOCK_WAY >= WAYS) begin : g_bad_lock
      $error("LOCK_WAY must name an existing way");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power of two, at least 16");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end

   fill_state_t state_q;
   logic [TAG_W-1:0]  pend_tag_q;
   logic [SET_W-1:0]  pend_idx_q;
   logic [WORD_W-1:0] pend_word_q;
   logic              resp_valid_q;
   logic              resp_hit_q;
   logic [DATA_W-1:0] resp_data_q;
   logic [SETS-1:0]   lock_q;

   logic [TAG_W-1:0]  cur_tag;
   logic [SET_W-1:0]  cur_idx;
   logic [WORD_W-1:0] cur_word;
   logic              in_fill;
   logic              accept;
   logic              fill_we;
   logic              plru_we;

   logic [WAYS-1:0][TAG_W-1:0] rd_tag;
   logic [WAYS-1:0]   rd_valid;
   logic [WAYS-1:1]   rd_plru;
   logic [WAYS-1:1]   new_plru;
   logic [DATA_W-1:0] rd_word;
   logic [WAYS-1:0]   hit_vec;
   logic              any_hit;
   logic [WAY_W-1:0]  hit_way;
   logic [WAY_W-1:0]  plru_way;
   logic [WAY_W-1:0]  vict_way;
   logic [WAY_W-1:0]  touch_way;
   logic [DATA_W-1:0] fill_word;

   assign in_fill  = (state_q == ST_FILL);
   assign cur_tag  = in_fill ? pend_tag_q  : fetch_addr_i[ADDR_W-1 -: TAG_W];
   assign cur_idx  = in_fill ? pend_idx_q  : fetch_addr_i[OFS_W +: SET_W];
   assign cur_word = in_fill ? pend_word_q : fetch_addr_i[BYTE_W +: WORD_W];

   assign fetch_ready_o = !in_fill && !flush_i;
   assign accept        = fetch_req_i && fetch_ready_o;
   assign fill_we       = in_fill && mem_ready_i;

   // tag compare per way
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == cur_tag);
   end
   assign any_hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end

   assign touch_way = fill_we ? vict_way : hit_way;
   assign plru_we   = fill_we || (accept && any_hit);
   assign fill_word = mem_line_i[cur_word*DATA_W +: DATA_W];

   wlock_store #(
      .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS),
      .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .idx_i      (cur_idx),
      .way_sel_i  (hit_way),
      .word_sel_i (cur_word),
      .rd_tag_o   (rd_tag),
      .rd_valid_o (rd_valid),
      .rd_plru_o  (rd_plru),
      .rd_word_o  (rd_word),
      .fill_we_i  (fill_we),
      .fill_way_i (vict_way),
      .fill_tag_i (cur_tag),
      .fill_line_i(mem_line_i),
      .plru_we_i  (plru_we),
      .plru_i     (new_plru)
   );

   wlock_plru #(.WAYS(WAYS)) plru_i (
      .bits_i  (rd_plru),
      .touch_i (touch_way),
      .bits_o  (new_plru),
      .victim_o(plru_way)
   );

   wlock_victim #(.WAYS(WAYS), .LOCK_WAY(LOCK_WAY)) victim_i (
      .valid_i   (rd_valid),
      .lock_i    (lock_q[cur_idx]),
      .plru_way_i(plru_way),
      .way_o     (vict_way)
   );

   // control state and response registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         pend_tag_q   <= '0;
         pend_idx_q   <= '0;
         pend_word_q  <= '0;
         resp_valid_q <= 1'b0;
         resp_hit_q   <= 1'b0;
         resp_data_q  <= '0;
      end else begin
         resp_valid_q <= 1'b0;
         if (accept) begin
            if (any_hit) begin
               resp_valid_q <= 1'b1;
               resp_hit_q   <= 1'b1;
               resp_data_q  <= rd_word;
            end else begin
               state_q     <= ST_FILL;
               pend_tag_q  <= cur_tag;
               pend_idx_q  <= cur_idx;
               pend_word_q <= cur_word;
            end
         end else if (fill_we) begin
            state_q      <= ST_IDLE;
            resp_valid_q <= 1'b1;
            resp_hit_q   <= 1'b0;
            resp_data_q  <= fill_word;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= '0;
      end else if (lock_we_i) begin
         lock_q[lock_set_i] <= lock_val_i;
      end
   end

   assign fetch_valid_o = resp_valid_q;
   assign fetch_hit_o   = resp_hit_q;
   assign fetch_data_o  = resp_data_q;
   assign mem_req_o     = in_fill;
   assign mem_addr_o    = {pend_tag_q, pend_idx_q, {OFS_W{1'b0}}};

   // R2: fetch addresses carry no byte offset
   a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_i |-> (fetch_addr_i[BYTE_W-1:0] == '0));

   // R2: an unanswered refill request holds its address
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

   // R3: a miss response follows a completed handshake
   a_r3_miss_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_o && !fetch_hit_o) |-> $past(mem_req_o && mem_ready_i));

   // R4: a hit response never follows a refill
   a_r4_hit_no_refill: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid_o && fetch_hit_o) |-> !$past(mem_req_o));

   // R5: one line is never held in two ways
   a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R6: a valid protected way in a locked set is never the fill target
   a_r6_lock_protects: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_we && lock_q[cur_idx] && rd_valid[LOCK_WAY]) |-> (vict_way != WAY_W'(LOCK_WAY)));

   // R10: no fetch is accepted while a refill is outstanding
   a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !fetch_ready_o);

endmodule

// File: tb/wlock_icache_tb_top.sv
module wlock_icache_tb_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         flush_i;
   logic         fetch_req_i;
   logic [31:0]  fetch_addr_i;
   logic         fetch_ready_o;
   logic         fetch_valid_o;
   logic         fetch_hit_o;
   logic [31:0]  fetch_data_o;
   logic         mem_req_o;
   logic [31:0]  mem_addr_o;
   logic         mem_ready_i;
   logic [127:0] mem_line_i;
   logic         lock_we_i;
   logic [5:0]   lock_set_i;
   logic         lock_val_i;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   wlock_icache dut_i (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .fetch_req_i(fetch_req_i), .fetch_addr_i(fetch_addr_i),
      .fetch_ready_o(fetch_ready_o), .fetch_valid_o(fetch_valid_o),
      .fetch_hit_o(fetch_hit_o), .fetch_data_o(fetch_data_o),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
      .mem_ready_i(mem_ready_i), .mem_line_i(mem_line_i),
      .lock_we_i(lock_we_i), .lock_set_i(lock_set_i), .lock_val_i(lock_val_i)
   );

   // backing store content is a pure function of the word address
   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[31:2], 2'b01} ^ 32'h5A5A_0000;
   endfunction

   always_comb begin
      for (int i = 0; i < 4; i++) begin
         mem_line_i[i*32 +: 32] = mem_word(mem_addr_o + 32'(i * 4));
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one fetch: drive, accept, serve a refill if one comes, check response
   task automatic fetch(input logic [31:0] addr, input bit exp_hit, input string req);
      int wait_n;
      @(negedge clk);
      check(fetch_ready_o, req, 32'(fetch_ready_o), 32'd1);
      fetch_req_i  = 1'b1;
      fetch_addr_i = addr;
      @(negedge clk);
      fetch_req_i = 1'b0;
      if (mem_req_o) begin
         check(!exp_hit, req, 32'(0), 32'(exp_hit));
         check(mem_addr_o == {addr[31:4], 4'h0}, "R2 line address", mem_addr_o,
               {addr[31:4], 4'h0});
         wait_n = 0;
         repeat (2) begin
            @(negedge clk);
            wait_n++;
         end
         check(mem_req_o && mem_addr_o == {addr[31:4], 4'h0}, "R2 request held",
               mem_addr_o, {addr[31:4], 4'h0});
         mem_ready_i = 1'b1;
         @(negedge clk);
         mem_ready_i = 1'b0;
         check(fetch_valid_o && !fetch_hit_o, "R3 miss response",
               {30'd0, fetch_valid_o, fetch_hit_o}, 32'd2);
         check(fetch_data_o == mem_word(addr), "R3 miss data", fetch_data_o, mem_word(addr));
         @(negedge clk);
         check(!fetch_valid_o, "R3 single strobe", 32'(fetch_valid_o), 32'd0);
      end else begin
         check(fetch_valid_o && fetch_hit_o == exp_hit, req,
               {30'd0, fetch_valid_o, fetch_hit_o}, {30'd0, 1'b1, exp_hit});
         check(fetch_data_o == mem_word(addr), "R4 hit data", fetch_data_o, mem_word(addr));
      end
   endtask

   task automatic set_lock(input logic [5:0] s, input logic v);
      @(negedge clk);
      lock_we_i  = 1'b1;
      lock_set_i = s;
      lock_val_i = v;
      @(negedge clk);
      lock_we_i = 1'b0;
   endtask

   // {expected hit, address}
   localparam logic [32:0] VEC [0:7] = '{
      {1'b0, 32'h0000_1000},  // R1 cold miss, set 0
      {1'b1, 32'h0000_1004},  // R4 same line, word 1
      {1'b1, 32'h0000_100C},  // R4 word 3
      {1'b0, 32'h0000_1010},  // R5 neighbouring set
      {1'b1, 32'h0000_1008},  // R4 first line still resident
      {1'b0, 32'h0000_2000},  // R5 same index, new tag
      {1'b1, 32'h0000_1000},  // R5 no aliasing
      {1'b1, 32'h0000_2004}   // R5 second way hits
   };

   initial begin
      rst_n = 1'b0; flush_i = 1'b0; fetch_req_i = 1'b0; fetch_addr_i = '0;
      mem_ready_i = 1'b0; lock_we_i = 1'b0; lock_set_i = '0; lock_val_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(fetch_ready_o && !fetch_valid_o && !mem_req_o, "R1 reset outputs",
            {29'd0, fetch_ready_o, fetch_valid_o, mem_req_o}, 32'd4);

      for (int i = 0; i < 8; i++) begin
         fetch(VEC[i][31:0], VEC[i][32], "R4/R5 table vector");
      end

      // R5 unlocked set 5: five conflicting lines evict the first one
      for (int k = 0; k < 5; k++) fetch(32'h50 + 32'(k) * 32'h400, 1'b0, "R5 fill");
      fetch(32'h50, 1'b0, "R5 first line evicted");

      // R6/R8 set 9: pin line, then overload the set
      fetch(32'h90, 1'b0, "R6 load critical line");
      set_lock(6'd9, 1'b1);
      fetch(32'h94, 1'b1, "R8 lock write keeps line");
      for (int k = 1; k <= 8; k++) fetch(32'h90 + 32'(k) * 32'h400, 1'b0, "R6 conflict miss");
      fetch(32'h90, 1'b1, "R6 pinned line survives");
      fetch(32'h90 + 32'd8 * 32'h400, 1'b1, "R6 other ways still refill");

      // R7 lock an empty set 12, first fill lands in the protected way
      set_lock(6'd12, 1'b1);
      fetch(32'hC0, 1'b0, "R7 fill protected way");
      for (int k = 1; k <= 6; k++) fetch(32'hC0 + 32'(k) * 32'h400, 1'b0, "R7 conflict miss");
      fetch(32'hC8, 1'b1, "R7 line protected");

      // R9 flush clears everything but keeps the lock
      @(negedge clk);
      flush_i = 1'b1;
      #1 check(!fetch_ready_o, "R10 ready low in flush", 32'(fetch_ready_o), 32'd0);
      @(negedge clk);
      flush_i = 1'b0;
      fetch(32'h1000, 1'b0, "R9 line gone after flush");
      fetch(32'h90, 1'b0, "R9 locked line gone after flush");
      for (int k = 1; k <= 5; k++) fetch(32'h90 + 32'(k) * 32'h400, 1'b0, "R9 conflict miss");
      fetch(32'h90, 1'b1, "R9 lock kept across flush");

      // R10 a request during a refill is ignored
      @(negedge clk);
      fetch_req_i = 1'b1; fetch_addr_i = 32'h0000_3144;
      @(negedge clk);
      check(mem_req_o && !fetch_ready_o, "R10 busy during refill",
            {30'd0, mem_req_o, fetch_ready_o}, 32'd2);
      fetch_addr_i = 32'h0000_1000;
      @(negedge clk);
      mem_ready_i = 1'b1;
      @(negedge clk);
      mem_ready_i = 1'b0; fetch_req_i = 1'b0;
      check(fetch_valid_o && fetch_data_o == mem_word(32'h3144), "R10 original answered",
            fetch_data_o, mem_word(32'h3144));
      @(negedge clk);
      check(!fetch_valid_o, "R10 ignored request unanswered", 32'(fetch_valid_o), 32'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule